// File: doc/BRIEF.md
# Dual-Retire Reorder Buffer

This block keeps the program order of in-flight instructions in an out-of-order core. It is a circular buffer of eight slots addressed by a head and a tail pointer. Dispatch claims one slot per cycle at the tail. The slot starts in the executing state, and the dispatcher is handed the slot index. Execution units later name that index on a writeback port to mark the slot written-back. A writeback also records whether a branch was mispredicted, whether the instruction trapped, and, for a store, the address and data.

Retirement always starts at the head. When the oldest slot and the one after it are both written back, both retire in the same cycle on two commit lanes. Each lane reports the architectural destination, the new physical tag and the old physical tag, so the old tag can be freed. A retiring store drives the store-commit port. Branch mispredictions and traps act only when they retire. The buffer then raises a flush, drops every younger slot and restarts allocation just past the flushing instruction.

Top module: `rob_dual_commit`

## Requirements
- R1: After reset the buffer is empty: alloc_ready_o is 1, alloc_idx_o is 0, cmt_valid_o is 0, and flush_o, trap_o and stq_valid_o are 0.
- R2: Each accepted allocation takes the slot given on alloc_idx_o. The index starts at 0 and rises by one per allocation, wrapping modulo 8. Once 8 slots are occupied, alloc_ready_o is 0.
- R3: A slot retires only after it has been written back, and only from the head. Writebacks to younger slots retire nothing while the head slot is still executing.
- R4: When the head slot and the next slot are both written back, both retire in the same cycle: cmt_valid_o is 2'b11, and lane 0 carries the older one. Lane 1 is never valid without lane 0.
- R5: Each valid commit lane reports the destination register, the physical tag and the old physical tag that were given at allocation.
- R6: A retiring store raises stq_valid_o with the address and data from its writeback. Two stores never retire in the same cycle, so the second one retires alone on the next cycle.
- R7: A branch that retires with its mispredict flag set raises flush_o in its retire cycle. alloc_ready_o is 0 in that cycle. In the next cycle the buffer is empty and alloc_idx_o points to the slot after the branch. This holds on either lane.
- R8: If the head slot is a fence, a trap or a mispredicted branch, it retires alone. The next slot stays and retires later unless a flush drops it.
- R9: A mispredict flag on the writeback of a slot not allocated as a branch is ignored: that slot retires with no flush.
- R10: A slot written back with its trap flag set raises flush_o and trap_o when it retires.
- R11: A writeback naming a slot that is not in the executing state is ignored. A slot allocated later into that position still waits for its own writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Dispatch offers an instruction |
| alloc_ready_o | output | 1 | A slot can be taken this cycle |
| alloc_idx_o | output | 3 | Slot index given to the offered instruction |
| alloc_ptag_i | input | 6 | New physical destination tag |
| alloc_areg_i | input | 5 | Architectural destination register |
| alloc_old_ptag_i | input | 6 | Physical tag previously mapped to the destination |
| alloc_is_branch_i | input | 1 | Instruction is a branch |
| alloc_is_store_i | input | 1 | Instruction is a store |
| alloc_is_fence_i | input | 1 | Instruction is a fence |
| wb_valid_i | input | 2 | Writeback valid per port |
| wb_idx_i | input | 2x3 | Slot index per writeback port |
| wb_mispredict_i | input | 2 | Branch resolved against its prediction |
| wb_trap_i | input | 2 | Instruction raised an exception |
| wb_st_addr_i | input | 2x32 | Store address per port |
| wb_st_data_i | input | 2x32 | Store data per port |
| cmt_valid_o | output | 2 | Commit lane valid, bit 0 is the oldest |
| cmt_areg_o | output | 2x5 | Retiring architectural destination |
| cmt_ptag_o | output | 2x6 | Retiring physical tag |
| cmt_old_ptag_o | output | 2x6 | Physical tag to free |
| stq_valid_o | output | 1 | Store retires this cycle |
| stq_addr_o | output | 32 | Retiring store address |
| stq_data_o | output | 32 | Retiring store data |
| flush_o | output | 1 | Younger work is squashed this cycle |
| trap_o | output | 1 | The flush comes from a trap |

## Verification
The main stimulus allocates four slots and writes them back youngest first under a table of completion masks. This separates three outcomes: no retire while the head is still executing, a single retire when only the head completes, and a paired retire when the head and the next slot complete together. Directed runs fill all eight slots, drain them in pairs, and check every lane field. Further runs place stores, fences, traps and mispredicted branches on lane 0 or lane 1 to tell solo retirement apart from pairing and to check where allocation restarts after a flush. A writeback to an idle slot and a mispredict flag on a non-branch confirm that both are ignored.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    ROB_CMT  = 2'd0,
    ROB_DONE = 2'd1,
    ROB_EXE  = 2'd2
  } rob_state_e;

  typedef struct packed {
    logic br;
    logic st;
    logic fence;
    logic mispred;
    logic trap;
  } rob_flags_t;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic [1:0]       ret_cnt_i,
  input  logic             flush_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [IDX_W-1:0] head_nxt;

  assign head_nxt = head_o + IDX_W'(ret_cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o <= '0;
      tail_o <= '0;
      cnt_o  <= '0;
    end else if (flush_i) begin
      head_o <= head_nxt;
      tail_o <= head_nxt;
      cnt_o  <= '0;
    end else begin
      head_o <= head_nxt;
      tail_o <= tail_o + IDX_W'(alloc_i);
      cnt_o  <= cnt_o + CNT_W'(alloc_i) - CNT_W'(ret_cnt_i);
    end
  end

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CNT_W'(DEPTH));

  a_r1_empty_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0) |-> (head_o == tail_o));

  a_r7_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_o == '0));
endmodule

// File: rtl/rob_retire_pick.sv
module rob_retire_pick
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  rob_state_e       st0_i,
  input  rob_state_e       st1_i,
  input  rob_flags_t       f0_i,
  input  rob_flags_t       f1_i,
  output logic             ret0_o,
  output logic             ret1_o,
  output logic [1:0]       ret_cnt_o,
  output logic             flush_o,
  output logic             trap_o
);
  logic solo0;

  // head that redirects or serializes retires alone
  assign solo0  = f0_i.mispred | f0_i.trap | f0_i.fence;
  assign ret0_o = (cnt_i != '0) && (st0_i == ROB_DONE);
  assign ret1_o = ret0_o && !solo0 && (cnt_i > CNT_W'(1)) &&
                  (st1_i == ROB_DONE) && !(f0_i.st && f1_i.st);
  assign ret_cnt_o = {1'b0, ret0_o} + {1'b0, ret1_o};
  assign flush_o = (ret0_o && (f0_i.mispred || f0_i.trap)) ||
                   (ret1_o && (f1_i.mispred || f1_i.trap));
  assign trap_o  = (ret0_o && f0_i.trap) || (ret1_o && f1_i.trap);
endmodule

// File: rtl/rob_dual_commit.sv
module rob_dual_commit
  import rob_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int PTAG_W   = 6,
  parameter int AREG_W   = 5,
  parameter int WB_PORTS = 2,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int CNT_W   = IDX_W + 1,
  localparam int LANES   = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               alloc_valid_i,
  output logic                               alloc_ready_o,
  output logic [IDX_W-1:0]                   alloc_idx_o,
  input  logic [PTAG_W-1:0]                  alloc_ptag_i,
  input  logic [AREG_W-1:0]                  alloc_areg_i,
  input  logic [PTAG_W-1:0]                  alloc_old_ptag_i,
  input  logic                               alloc_is_branch_i,
  input  logic                               alloc_is_store_i,
  input  logic                               alloc_is_fence_i,
  input  logic [WB_PORTS-1:0]                wb_valid_i,
  input  logic [WB_PORTS-1:0][IDX_W-1:0]     wb_idx_i,
  input  logic [WB_PORTS-1:0]                wb_mispredict_i,
  input  logic [WB_PORTS-1:0]                wb_trap_i,
  input  logic [WB_PORTS-1:0][ADDR_W-1:0]    wb_st_addr_i,
  input  logic [WB_PORTS-1:0][DATA_W-1:0]    wb_st_data_i,
  output logic [LANES-1:0]                   cmt_valid_o,
  output logic [LANES-1:0][AREG_W-1:0]       cmt_areg_o,
  output logic [LANES-1:0][PTAG_W-1:0]       cmt_ptag_o,
  output logic [LANES-1:0][PTAG_W-1:0]       cmt_old_ptag_o,
  output logic                               stq_valid_o,
  output logic [ADDR_W-1:0]                  stq_addr_o,
  output logic [DATA_W-1:0]                  stq_data_o,
  output logic                               flush_o,
  output logic                               trap_o
);
  rob_state_e        st_q   [DEPTH];
  rob_flags_t        flg_q  [DEPTH];
  logic [PTAG_W-1:0] ptag_q [DEPTH];
  logic [PTAG_W-1:0] old_q  [DEPTH];
  logic [AREG_W-1:0] areg_q [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  logic [IDX_W-1:0] head_w, head1_w, tail_w;
  logic [CNT_W-1:0] cnt_w;
  logic [1:0]       ret_cnt_w;
  logic             ret0_w, ret1_w, flush_w, trap_w, alloc_fire;

  assign head1_w       = head_w + IDX_W'(1);
  assign alloc_ready_o = (cnt_w != CNT_W'(DEPTH)) && !flush_w;
  assign alloc_fire    = alloc_valid_i && alloc_ready_o;
  assign alloc_idx_o   = tail_w;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .alloc_i   (alloc_fire),
    .ret_cnt_i (ret_cnt_w),
    .flush_i   (flush_w),
    .head_o    (head_w),
    .tail_o    (tail_w),
    .cnt_o     (cnt_w)
  );

  rob_retire_pick #(.DEPTH(DEPTH)) u_pick (
    .cnt_i     (cnt_w),
    .st0_i     (st_q[head_w]),
    .st1_i     (st_q[head1_w]),
    .f0_i      (flg_q[head_w]),
    .f1_i      (flg_q[head1_w]),
    .ret0_o    (ret0_w),
    .ret1_o    (ret1_w),
    .ret_cnt_o (ret_cnt_w),
    .flush_o   (flush_w),
    .trap_o    (trap_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]   <= ROB_CMT;
        flg_q[i]  <= '0;
        ptag_q[i] <= '0;
        old_q[i]  <= '0;
        areg_q[i] <= '0;
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else if (flush_w) begin
      for (int i = 0; i < DEPTH; i++) st_q[i] <= ROB_CMT;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if ((ret0_w && head_w == IDX_W'(i)) || (ret1_w && head1_w == IDX_W'(i)))
          st_q[i] <= ROB_CMT;
        for (int w = 0; w < WB_PORTS; w++) begin
          // late or stray writebacks to idle slots are dropped
          if (wb_valid_i[w] && wb_idx_i[w] == IDX_W'(i) && st_q[i] == ROB_EXE) begin
            st_q[i]          <= ROB_DONE;
            flg_q[i].mispred <= wb_mispredict_i[w] & flg_q[i].br;
            flg_q[i].trap    <= wb_trap_i[w];
            addr_q[i]        <= wb_st_addr_i[w];
            data_q[i]        <= wb_st_data_i[w];
          end
        end
        if (alloc_fire && tail_w == IDX_W'(i)) begin
          st_q[i]          <= ROB_EXE;
          ptag_q[i]        <= alloc_ptag_i;
          old_q[i]         <= alloc_old_ptag_i;
          areg_q[i]        <= alloc_areg_i;
          flg_q[i].br      <= alloc_is_branch_i;
          flg_q[i].st      <= alloc_is_store_i;
          flg_q[i].fence   <= alloc_is_fence_i;
          flg_q[i].mispred <= 1'b0;
          flg_q[i].trap    <= 1'b0;
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IDX_W-1:0] slot;
    assign slot              = head_w + IDX_W'(l);
    assign cmt_areg_o[l]     = areg_q[slot];
    assign cmt_ptag_o[l]     = ptag_q[slot];
    assign cmt_old_ptag_o[l] = old_q[slot];
  end

  assign cmt_valid_o = {ret1_w, ret0_w};
  assign stq_valid_o = (ret0_w && flg_q[head_w].st) || (ret1_w && flg_q[head1_w].st);
  assign stq_addr_o  = (ret0_w && flg_q[head_w].st) ? addr_q[head_w] : addr_q[head1_w];
  assign stq_data_o  = (ret0_w && flg_q[head_w].st) ? data_q[head_w] : data_q[head1_w];
  assign flush_o     = flush_w;
  assign trap_o      = trap_w;

  a_r2_alloc_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_fire |=> (st_q[$past(tail_w)] == ROB_EXE));

  a_r4_lane_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmt_valid_o[1] |-> cmt_valid_o[0]);

  a_r3_retire_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmt_valid_o[0] |=> (st_q[$past(head_w)] == ROB_CMT));

  a_r6_one_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ret0_w && flg_q[head_w].st, ret1_w && flg_q[head1_w].st}) <= 1);
endmodule

// File: tb/tb_rob_dual_commit.sv
`timescale 1ns/1ps
module tb_rob_dual_commit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            alloc_valid, alloc_ready;
  logic [2:0]      alloc_idx;
  logic [5:0]      alloc_ptag, alloc_old;
  logic [4:0]      alloc_areg;
  logic            a_br, a_st, a_fe;
  logic [1:0]      wb_valid, wb_mis, wb_trap;
  logic [1:0][2:0] wb_idx;
  logic [1:0][31:0] wb_addr, wb_data;
  logic [1:0]      cmt_valid;
  logic [1:0][4:0] cmt_areg;
  logic [1:0][5:0] cmt_ptag, cmt_old;
  logic            stq_valid, flush, trap;
  logic [31:0]     stq_addr, stq_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  rob_dual_commit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(alloc_valid), .alloc_ready_o(alloc_ready), .alloc_idx_o(alloc_idx),
    .alloc_ptag_i(alloc_ptag), .alloc_areg_i(alloc_areg), .alloc_old_ptag_i(alloc_old),
    .alloc_is_branch_i(a_br), .alloc_is_store_i(a_st), .alloc_is_fence_i(a_fe),
    .wb_valid_i(wb_valid), .wb_idx_i(wb_idx), .wb_mispredict_i(wb_mis), .wb_trap_i(wb_trap),
    .wb_st_addr_i(wb_addr), .wb_st_data_i(wb_data),
    .cmt_valid_o(cmt_valid), .cmt_areg_o(cmt_areg), .cmt_ptag_o(cmt_ptag),
    .cmt_old_ptag_o(cmt_old), .stq_valid_o(stq_valid), .stq_addr_o(stq_addr),
    .stq_data_o(stq_data), .flush_o(flush), .trap_o(trap)
  );

  // {completion mask of slots 3..0, expected lanes after head completes}
  localparam logic [5:0] VEC [8] = '{
    {4'b0001, 2'd1}, {4'b0011, 2'd2}, {4'b0111, 2'd2}, {4'b1111, 2'd2},
    {4'b0010, 2'd0}, {4'b1110, 2'd0}, {4'b0101, 2'd1}, {4'b1001, 2'd1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #0.5;
  endtask

  task automatic idle_inputs();
    alloc_valid = 0; alloc_ptag = '0; alloc_old = '0; alloc_areg = '0;
    a_br = 0; a_st = 0; a_fe = 0;
    wb_valid = '0; wb_mis = '0; wb_trap = '0; wb_idx = '0; wb_addr = '0; wb_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #0.5;
  endtask

  // slot contents derive from areg: ptag = 16+areg, old = 32+areg
  task automatic alloc(logic [4:0] areg, logic br, logic st, logic fe);
    alloc_valid = 1; alloc_areg = areg; alloc_ptag = 6'(16 + areg); alloc_old = 6'(32 + areg);
    a_br = br; a_st = st; a_fe = fe;
    tick();
    alloc_valid = 0; a_br = 0; a_st = 0; a_fe = 0;
  endtask

  task automatic wb(int p, logic [2:0] idx, logic mis, logic tr, logic [31:0] ad, logic [31:0] da);
    wb_valid[p] = 1; wb_idx[p] = idx; wb_mis[p] = mis; wb_trap[p] = tr;
    wb_addr[p] = ad; wb_data[p] = da;
  endtask

  task automatic wb_clear();
    wb_valid = '0; wb_mis = '0; wb_trap = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    do_reset();
    // R1 reset state
    chk("R1 ready", alloc_ready, 1);
    chk("R1 idx", alloc_idx, 0);
    chk("R1 cmt", cmt_valid, 0);
    chk("R1 flush", {29'b0, flush, trap, stq_valid}, 0);

    // R3/R4 table walk: youngest first, head last
    for (int v = 0; v < 8; v++) begin
      logic [3:0] m;
      m = VEC[v][5:2];
      do_reset();
      for (int i = 0; i < 4; i++) alloc(5'(i + 1), 0, 0, 0);
      for (int j = 3; j >= 1; j--) begin
        if (m[j]) begin
          wb(0, 3'(j), 0, 0, '0, '0);
          tick();
          wb_clear();
        end
        chk("R3 no retire before head", cmt_valid, 0);
      end
      if (m[0]) begin
        wb(0, 3'd0, 0, 0, '0, '0);
        tick();
        wb_clear();
      end
      chk("R4 lanes", $countones(cmt_valid), VEC[v][1:0]);
      if (m[0]) chk("R5 lane0 areg", cmt_areg[0], 1);
    end

    // R2 fill, R4/R5 drain in pairs
    do_reset();
    for (int i = 0; i < 8; i++) begin
      chk("R2 idx", alloc_idx, i);
      alloc(5'(i + 1), 0, 0, 0);
    end
    chk("R2 full", alloc_ready, 0);
    for (int k = 3; k >= 1; k--) begin
      wb(0, 3'(2 * k), 0, 0, '0, '0);
      wb(1, 3'(2 * k + 1), 0, 0, '0, '0);
      tick();
      wb_clear();
    end
    wb(0, 3'd1, 0, 0, '0, '0);
    tick();
    wb_clear();
    chk("R3 head pending", cmt_valid, 0);
    wb(0, 3'd0, 0, 0, '0, '0);
    tick();
    wb_clear();
    for (int k = 0; k < 4; k++) begin
      chk("R4 pair", cmt_valid, 2'b11);
      chk("R5 areg0", cmt_areg[0], 2 * k + 1);
      chk("R5 areg1", cmt_areg[1], 2 * k + 2);
      chk("R5 ptag1", cmt_ptag[1], 16 + 2 * k + 2);
      chk("R5 old0", cmt_old[0], 32 + 2 * k + 1);
      tick();
    end
    chk("R2 drained ready", alloc_ready, 1);
    chk("R2 wrap idx", alloc_idx, 0);

    // R6 two stores retire one per cycle
    do_reset();
    alloc(1, 0, 1, 0);
    alloc(2, 0, 1, 0);
    wb(0, 3'd0, 0, 0, 32'hA000_0000, 32'h1111);
    wb(1, 3'd1, 0, 0, 32'hA000_0004, 32'h2222);
    tick();
    wb_clear();
    chk("R6 solo store", cmt_valid, 2'b01);
    chk("R6 stq valid", stq_valid, 1);
    chk("R6 addr0", stq_addr, 32'hA000_0000);
    chk("R6 data0", stq_data, 32'h1111);
    tick();
    chk("R6 second store", cmt_valid, 2'b01);
    chk("R6 addr1", stq_addr, 32'hA000_0004);
    chk("R6 data1", stq_data, 32'h2222);

    // R7/R8 mispredicted branch at head
    do_reset();
    alloc(1, 1, 0, 0);
    alloc(2, 0, 0, 0);
    alloc(3, 0, 0, 0);
    wb(0, 3'd0, 1, 0, '0, '0);
    wb(1, 3'd1, 0, 0, '0, '0);
    tick();
    wb_clear();
    chk("R8 branch alone", cmt_valid, 2'b01);
    chk("R7 flush", flush, 1);
    chk("R7 no alloc in flush", alloc_ready, 0);
    chk("R10 no trap", trap, 0);
    tick();
    chk("R7 empty after", cmt_valid, 0);
    chk("R7 ready", alloc_ready, 1);
    chk("R7 restart idx", alloc_idx, 1);

    // R7 mispredict on lane 1
    do_reset();
    alloc(1, 0, 0, 0);
    alloc(2, 1, 0, 0);
    alloc(3, 0, 0, 0);
    wb(0, 3'd0, 0, 0, '0, '0);
    wb(1, 3'd1, 1, 0, '0, '0);
    tick();
    wb_clear();
    chk("R7 lane1 pair", cmt_valid, 2'b11);
    chk("R7 lane1 flush", flush, 1);
    tick();
    chk("R7 lane1 restart idx", alloc_idx, 2);
    chk("R7 lane1 empty", cmt_valid, 0);

    // R10 trap
    do_reset();
    alloc(1, 0, 0, 0);
    alloc(2, 0, 0, 0);
    wb(0, 3'd0, 0, 1, '0, '0);
    wb(1, 3'd1, 0, 0, '0, '0);
    tick();
    wb_clear();
    chk("R10 trap", {30'b0, flush, trap}, 2'b11);
    chk("R8 trap alone", cmt_valid, 2'b01);

    // R9 mispredict on non-branch ignored
    do_reset();
    alloc(1, 0, 0, 0);
    alloc(2, 0, 0, 0);
    wb(0, 3'd0, 1, 0, '0, '0);
    wb(1, 3'd1, 0, 0, '0, '0);
    tick();
    wb_clear();
    chk("R9 pair", cmt_valid, 2'b11);
    chk("R9 no flush", flush, 0);

    // R8 fence retires alone, follower survives
    do_reset();
    alloc(1, 0, 0, 1);
    alloc(2, 0, 0, 0);
    wb(0, 3'd0, 0, 0, '0, '0);
    wb(1, 3'd1, 0, 0, '0, '0);
    tick();
    wb_clear();
    chk("R8 fence alone", cmt_valid, 2'b01);
    chk("R8 fence no flush", flush, 0);
    tick();
    chk("R8 follower", cmt_valid, 2'b01);
    chk("R8 follower areg", cmt_areg[0], 2);

    // R11 stray writeback to idle slot
    do_reset();
    wb(0, 3'd0, 0, 0, '0, '0);
    tick();
    wb_clear();
    alloc(1, 0, 0, 0);
    chk("R11 stray ignored", cmt_valid, 0);
    tick();
    chk("R11 still waiting", cmt_valid, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule